// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block sits between a processor that issues 22-bit byte addresses with 16-bit words and a slower backing store. It keeps one entry per 12-bit index. Each entry holds a 9-bit tag, a valid flag and two data bytes, and each of these fields carries its own parity bit. A read that finds its word in the cache is answered without a backing-store access. Every write goes out to the backing store, and the cache is updated as the same request completes, so the cache never holds newer data than memory.

The processor raises a one-cycle request when `cpu_ready` is high and gets a one-cycle `cpu_ack` later, together with read data and a hit flag. An address seen on the DMA snoop port drops the matching entry. A small control register switches the cache on, forces bad parity for diagnostics and starts a full invalidation sweep. A six-bit history register records the outcome of the most recent references.

Top module: `cache_wt_ctrl`

## Requirements
- R1: The address splits into tag = bits 21..13, index = bits 12..1 and byte select = bit 0. A reference hits only when the indexed entry is valid, its stored tag equals the tag field, and the tag, low-byte and high-byte parity all check. Two addresses with the same index and different tags evict each other.
- R2: Reads are word reads and ignore bit 0. A cacheable read miss fetches the word from the backing store, fills the entry and marks it valid. A read hit returns the cached word and issues no backing-store read.
- R3: A word write (`cpu_op`=1) updates the entry on a hit. On a miss to a cacheable address it allocates a valid entry holding the written word.
- R4: A byte write (`cpu_op`=2) changes only the selected byte: bit 0 = 0 takes `cpu_wdata[7:0]` into the low byte, and bit 0 = 1 takes `cpu_wdata[15:8]` into the high byte. It changes the entry only on a hit. A byte-write miss never allocates.
- R5: Every write goes to the backing store with `mem_we`=1 and lane mask `mem_bmask` set to 11 for a word, 01 for a low byte and 10 for a high byte. The processor is acknowledged after `mem_ack`.
- R6: A `dma_valid` pulse whose address matches the index and tag of a valid entry clears that entry. A DMA address with the same index and a different tag leaves the entry intact.
- R7: References whose tag field is all ones (the I/O page, 0x3FE000 to 0x3FFFFF) or that carry `cpu_nocache` never hit and never allocate.
- R8: A control write (`ctl_we`) loads bit 0 = enable and bit 1 = force parity, and both read back on `ctl_q`. While enable is 0, no reference hits and none allocates, but entries already present stay valid.
- R9: While force parity is set, every entry written gets all three parity bits inverted, so its next lookup misses. That lookup refills the entry with correct parity once force is clear, and the following read hits.
- R10: Writing `ctl_wdata` bit 2 = 1 invalidates all 4096 entries, one per clock. `cpu_ready` stays low for 4097 cycles from the write, and afterwards every reference misses.
- R11: `hist` shifts left once per processor reference, taking 1 for a hit and 0 for a miss into bit 0. At `cpu_ack`, bit 0 equals `cpu_hit`.
- R12: After reset `cpu_ready`=1, `cpu_ack`=0, `mem_req`=0, `hist`=0, `ctl_q`=0 (cache off), and all entries are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | One-cycle request, taken while cpu_ready is high |
| cpu_op | input | 2 | 0 read, 1 word write, 2 byte write |
| cpu_addr | input | 22 | Byte address |
| cpu_wdata | input | 16 | Write data, byte on its lane |
| cpu_nocache | input | 1 | Bypass flag from the memory management unit |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Read data, valid with cpu_ack |
| cpu_hit | output | 1 | Reference hit, valid with cpu_ack |
| mem_req | output | 1 | Backing-store request, held until mem_ack |
| mem_we | output | 1 | Backing-store write |
| mem_addr | output | 22 | Backing-store byte address |
| mem_wdata | output | 16 | Backing-store write data |
| mem_bmask | output | 2 | Byte-lane mask for writes |
| mem_ack | input | 1 | Backing-store completion |
| mem_rdata | input | 16 | Backing-store read data, valid with mem_ack |
| dma_valid | input | 1 | Snooped DMA transfer this cycle |
| dma_addr | input | 22 | Snooped DMA address |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | bit0 enable, bit1 force parity, bit2 flush all |
| ctl_q | output | 2 | Current force-parity and enable bits |
| hist | output | 6 | Hit/miss history, newest in bit 0 |

## Verification
The lookup is driven with a repeated read of one word, which separates the fill path from the hit path, and with the same word read at its odd byte, which shows that byte select plays no part in reads. A second tag at the same index shows eviction. Word and byte writes are sent to present and absent lines to separate update, allocate and no-allocate. The same lines are then reached through I/O-page addresses, the bypass flag, a disabled cache, forced parity and DMA addresses with matching and non-matching tags, which separates each route by which an entry may be lost or refused.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [1:0] {
        OP_RD = 2'd0,
        OP_WW = 2'd1,
        OP_WB = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOOK  = 2'd1,
        ST_MEM   = 2'd2,
        ST_FLUSH = 2'd3
    } st_e;
endpackage

// File: rtl/cache_store.sv
module cache_store #(
    parameter int IDX_W = 12,
    parameter int ENT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ENT_W-1:0] rd_ent,
    output logic             rd_vld,
    input  logic [IDX_W-1:0] sn_idx,
    output logic [ENT_W-1:0] sn_ent,
    output logic             sn_vld,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_ent,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ENT_W-1:0] ent_q [DEPTH];
    logic [DEPTH-1:0] vld_q;

    assign rd_ent = ent_q[rd_idx];
    assign rd_vld = vld_q[rd_idx];
    assign sn_ent = ent_q[sn_idx];
    assign sn_vld = vld_q[sn_idx];

    always_ff @(posedge clk) begin
        if (wr_en) ent_q[wr_idx] <= wr_ent;
    end

    // a clear issued in the same cycle as a write lands last and wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (wr_en)  vld_q[wr_idx]  <= 1'b1;
            if (clr_en) vld_q[clr_idx] <= 1'b0;
        end
    end

    // R6: a cleared entry is invalid in the following cycle
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !vld_q[$past(clr_idx)]);
endmodule

// File: rtl/cache_pack.sv
module cache_pack #(
    parameter int TAG_W = 9
) (
    input  logic [TAG_W-1:0]  tag,
    input  logic [15:0]       data,
    input  logic              flip,
    output logic [TAG_W+18:0] ent
);
    // layout: {tag parity, tag, high parity, high byte, low parity, low byte}
    // tag and low byte use even parity, high byte uses odd parity
    assign ent = {(^tag) ^ flip, tag,
                  (~^data[15:8]) ^ flip, data[15:8],
                  (^data[7:0]) ^ flip, data[7:0]};
endmodule

// File: rtl/cache_match.sv
module cache_match #(
    parameter int TAG_W = 9
) (
    input  logic [TAG_W+18:0] ent,
    input  logic              vld,
    input  logic [TAG_W-1:0]  label,
    output logic              line_hit,
    output logic [15:0]       data
);
    logic             tp, p1, p0;
    logic [TAG_W-1:0] tag;
    logic [7:0]       b1, b0;
    logic             par_ok;

    assign {tp, tag, p1, b1, p0, b0} = ent;
    assign par_ok   = (tp == ^tag) && (p1 == ~^b1) && (p0 == ^b0);
    assign line_hit = vld && (tag == label) && par_ok;
    assign data     = {b1, b0};
endmodule

// File: rtl/cache_wt_ctrl.sv
module cache_wt_ctrl #(
    parameter int ADDR_W = 22,
    parameter int IDX_W  = 12,
    parameter int HIST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [15:0]       cpu_wdata,
    input  logic              cpu_nocache,
    output logic              cpu_ready,
    output logic              cpu_ack,
    output logic [15:0]       cpu_rdata,
    output logic              cpu_hit,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic [1:0]        mem_bmask,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata,
    input  logic              dma_valid,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic              ctl_we,
    input  logic [2:0]        ctl_wdata,
    output logic [1:0]        ctl_q,
    output logic [HIST_W-1:0] hist
);
    import wtc_pkg::*;

    localparam int TAG_W = ADDR_W - IDX_W - 1;
    localparam int ENT_W = TAG_W + 19;

    typedef struct packed {
        st_e               st;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       wdata;
        logic              nc;
        logic              cach;
        logic              en;
        logic              frc;
        logic              fpend;
        logic [IDX_W-1:0]  fidx;
        logic              mreq;
        logic              mwe;
        logic              ack;
        logic [15:0]       rdata;
        logic              hit;
        logic [HIST_W-1:0] hist;
    } ctl_t;

    ctl_t r_q, r_d;

    logic [TAG_W-1:0] lk_label, dm_label;
    logic [IDX_W-1:0] lk_idx, dm_idx;
    logic [ENT_W-1:0] rd_ent, sn_ent, wr_ent;
    logic             rd_vld, sn_vld;
    logic             m_hit;
    logic [15:0]      m_data;
    logic             look_cach, look_hit;
    logic             st_wr_en, clr_en;
    logic [IDX_W-1:0] clr_idx;
    logic [15:0]      pk_data;

    assign lk_label = r_q.addr[ADDR_W-1 -: TAG_W];
    assign lk_idx   = r_q.addr[IDX_W:1];
    assign dm_label = dma_addr[ADDR_W-1 -: TAG_W];
    assign dm_idx   = dma_addr[IDX_W:1];

    cache_store #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_idx), .rd_ent(rd_ent), .rd_vld(rd_vld),
        .sn_idx(dm_idx), .sn_ent(sn_ent), .sn_vld(sn_vld),
        .wr_en(st_wr_en), .wr_idx(lk_idx), .wr_ent(wr_ent),
        .clr_en(clr_en), .clr_idx(clr_idx)
    );

    cache_match #(.TAG_W(TAG_W)) u_match (
        .ent(rd_ent), .vld(rd_vld), .label(lk_label),
        .line_hit(m_hit), .data(m_data)
    );

    cache_pack #(.TAG_W(TAG_W)) u_pack (
        .tag(lk_label), .data(pk_data), .flip(r_q.frc), .ent(wr_ent)
    );

    // cacheable: enabled, not bypassed, not in the I/O page
    assign look_cach = r_q.en && !r_q.nc && !(&lk_label);
    assign look_hit  = look_cach && m_hit;

    always_comb begin
        r_d      = r_q;
        r_d.ack  = 1'b0;
        st_wr_en = 1'b0;
        clr_en   = 1'b0;
        clr_idx  = dm_idx;
        pk_data  = r_q.wdata;

        case (r_q.st)
            ST_IDLE: begin
                if (r_q.fpend) begin
                    r_d.st   = ST_FLUSH;
                    r_d.fidx = '0;
                end else if (cpu_req) begin
                    r_d.st    = ST_LOOK;
                    r_d.op    = op_e'(cpu_op);
                    r_d.addr  = cpu_addr;
                    r_d.wdata = cpu_wdata;
                    r_d.nc    = cpu_nocache;
                end
            end
            ST_LOOK: begin
                r_d.cach = look_cach;
                r_d.hit  = look_hit;
                r_d.hist = {r_q.hist[HIST_W-2:0], look_hit};
                if (r_q.op == OP_RD) begin
                    if (look_hit) begin
                        r_d.ack   = 1'b1;
                        r_d.rdata = m_data;
                        r_d.st    = ST_IDLE;
                    end else begin
                        r_d.mreq = 1'b1;
                        r_d.mwe  = 1'b0;
                        r_d.st   = ST_MEM;
                    end
                end else begin
                    r_d.mreq = 1'b1;
                    r_d.mwe  = 1'b1;
                    r_d.st   = ST_MEM;
                    if (r_q.op == OP_WB)
                        pk_data = r_q.addr[0] ? {r_q.wdata[15:8], m_data[7:0]}
                                              : {m_data[15:8], r_q.wdata[7:0]};
                    // hits keep the entry coherent; only cacheable word writes allocate
                    st_wr_en = m_hit || (r_q.op == OP_WW && look_cach);
                end
            end
            ST_MEM: begin
                if (mem_ack) begin
                    r_d.mreq = 1'b0;
                    r_d.ack  = 1'b1;
                    r_d.st   = ST_IDLE;
                    if (r_q.op == OP_RD) begin
                        r_d.rdata = mem_rdata;
                        pk_data   = mem_rdata;
                        st_wr_en  = r_q.cach;
                    end
                end
            end
            ST_FLUSH: begin
                clr_en   = 1'b1;
                clr_idx  = r_q.fidx;
                r_d.fidx = r_q.fidx + 1'b1;
                if (&r_q.fidx) begin
                    r_d.st    = ST_IDLE;
                    r_d.fpend = 1'b0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        // snoop: the sweep clears everything anyway, so it owns the port then
        if (r_q.st != ST_FLUSH && dma_valid && sn_vld &&
            sn_ent[ENT_W-2 -: TAG_W] == dm_label) begin
            clr_en  = 1'b1;
            clr_idx = dm_idx;
        end

        if (ctl_we) begin
            r_d.en  = ctl_wdata[0];
            r_d.frc = ctl_wdata[1];
            if (ctl_wdata[2]) r_d.fpend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cpu_ready = (r_q.st == ST_IDLE) && !r_q.fpend;
    assign cpu_ack   = r_q.ack;
    assign cpu_rdata = r_q.rdata;
    assign cpu_hit   = r_q.hit;
    assign mem_req   = r_q.mreq;
    assign mem_we    = r_q.mwe;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;
    assign mem_bmask = (r_q.op == OP_WB) ? (r_q.addr[0] ? 2'b10 : 2'b01) : 2'b11;
    assign ctl_q     = {r_q.frc, r_q.en};
    assign hist      = r_q.hist;

    // R2: a read hit completes without a backing-store request
    a_r2_hit_skips_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOOK && r_q.op == OP_RD && look_hit) |=> (!mem_req && cpu_ack));
    // R5: every write is sent out
    a_r5_write_out: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOOK && r_q.op != OP_RD) |=> (mem_req && mem_we));
    // R4: byte-write misses leave the store untouched
    a_r4_byte_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOOK && r_q.op == OP_WB && !m_hit) |-> !st_wr_en);
    // R7: I/O-page fetches are never filled
    a_r7_iopage_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MEM && (&lk_label)) |-> !st_wr_en);
    // R10: no requests accepted during the sweep
    a_r10_flush_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FLUSH) |-> !cpu_ready);
    // R11: newest history bit matches the reported outcome
    a_r11_hist_newest: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> (hist[0] == cpu_hit));
endmodule

// File: tb/cache_wt_ctrl_test.sv
module cache_wt_ctrl_test;
    localparam int DEPTH = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [1:0]  cpu_op = 2'd0;
    logic [21:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_nocache = 1'b0;
    logic        cpu_ready, cpu_ack, cpu_hit;
    logic [15:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [21:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [1:0]  mem_bmask;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        dma_valid = 1'b0;
    logic [21:0] dma_addr = '0;
    logic        ctl_we = 1'b0;
    logic [2:0]  ctl_wdata = '0;
    logic [1:0]  ctl_q;
    logic [5:0]  hist;

    always #5 clk = ~clk;

    cache_wt_ctrl uut (.*);

    int n_chk = 0, n_fail = 0;
    int n_mrd = 0, n_mwr = 0, n_wr_issued = 0;
    logic [1:0] last_mask = '0;
    logic [1:0] mcnt = '0;

    logic [15:0] dev  [int];
    logic [15:0] refm [int];
    bit          rv   [int];
    logic [8:0]  rt   [int];
    bit          rb   [int];
    bit          m_en = 0, m_frc = 0;
    logic [5:0]  rh = '0;

    typedef struct {
        bit          rd;
        logic [15:0] data;
        logic        hit;
        logic [5:0]  hist;
        string       req;
    } exp_t;
    exp_t sbq[$];

    function automatic logic [15:0] dflt(int w);
        return w[15:0] ^ 16'hA5C3;
    endfunction

    function automatic logic [15:0] dev_rd(int w);
        return dev.exists(w) ? dev[w] : dflt(w);
    endfunction

    function automatic logic [15:0] ref_rd(int w);
        return refm.exists(w) ? refm[w] : dflt(w);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // backing-store model: answers three cycles after a request
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            if (mcnt == 2'd2) begin
                mcnt    <= '0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    logic [15:0] cur;
                    cur = dev_rd(int'(mem_addr[21:1]));
                    if (mem_bmask[0]) cur[7:0]  = mem_wdata[7:0];
                    if (mem_bmask[1]) cur[15:8] = mem_wdata[15:8];
                    dev[int'(mem_addr[21:1])] = cur;
                    last_mask <= mem_bmask;
                    n_mwr++;
                end else begin
                    mem_rdata <= dev_rd(int'(mem_addr[21:1]));
                    n_mrd++;
                end
            end else begin
                mcnt <= mcnt + 2'd1;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && cpu_ack) begin
            if (sbq.size() == 0) begin
                chk(0, "R11 unexpected ack", 32'(cpu_ack), 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (e.rd) chk(cpu_rdata == e.data, {e.req, " data"}, 32'(cpu_rdata), 32'(e.data));
                chk(cpu_hit == e.hit, {e.req, " hit"}, 32'(cpu_hit), 32'(e.hit));
                chk(hist == e.hist, "R11 history", 32'(hist), 32'(e.hist));
            end
        end
    end

    task automatic op(input logic [1:0] k, input logic [21:0] a, input logic [15:0] d,
                      input logic nc, input string req);
        int w = int'(a[21:1]);
        int ix = int'(a[12:1]);
        logic [8:0] tg = a[21:13];
        bit cach = m_en && !nc && (tg != 9'h1FF);
        bit lh = rv.exists(ix) && rv[ix] && rt[ix] == tg && !rb[ix];
        bit h = cach && lh;
        exp_t e;
        while (!cpu_ready) @(negedge clk);
        rh = {rh[4:0], h};
        e.rd = (k == 2'd0); e.hit = h; e.hist = rh; e.req = req; e.data = ref_rd(w);
        if (k == 2'd0) begin
            if (!h && cach) begin rv[ix] = 1; rt[ix] = tg; rb[ix] = m_frc; end
        end else if (k == 2'd1) begin
            refm[w] = d;
            n_wr_issued++;
            if (lh || cach) begin rv[ix] = 1; rt[ix] = tg; rb[ix] = m_frc; end
        end else begin
            logic [15:0] cur = ref_rd(w);
            if (a[0]) cur[15:8] = d[15:8]; else cur[7:0] = d[7:0];
            refm[w] = cur;
            n_wr_issued++;
            if (lh) rb[ix] = m_frc;
        end
        sbq.push_back(e);
        cpu_req = 1'b1; cpu_op = k; cpu_addr = a; cpu_wdata = d; cpu_nocache = nc;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic drain();
        while (sbq.size() != 0 || !cpu_ready) @(negedge clk);
    endtask

    task automatic ctl(input logic [2:0] v);
        drain();
        ctl_we = 1'b1; ctl_wdata = v;
        m_en = v[0]; m_frc = v[1];
        if (v[2]) rv.delete();
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic dma(input logic [21:0] a, input logic [15:0] d);
        int ix = int'(a[12:1]);
        drain();
        dev[int'(a[21:1])] = d;
        refm[int'(a[21:1])] = d;
        if (rv.exists(ix) && rv[ix] && rt[ix] == a[21:13]) rv[ix] = 0;
        dma_valid = 1'b1; dma_addr = a;
        @(negedge clk);
        dma_valid = 1'b0;
    endtask

    localparam logic [21:0] A = 22'h001234;
    localparam logic [21:0] B = 22'h002468;
    localparam logic [21:0] C = 22'h004000;
    localparam logic [21:0] F = 22'h0A0100;
    localparam logic [21:0] IO = 22'h3FE010;

    initial begin
        int rd0, lowc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(cpu_ready == 1'b1, "R12 ready", 32'(cpu_ready), 1);
        chk(cpu_ack == 1'b0, "R12 ack", 32'(cpu_ack), 0);
        chk(mem_req == 1'b0, "R12 mem_req", 32'(mem_req), 0);
        chk(hist == 6'd0, "R12 hist", 32'(hist), 0);
        chk(ctl_q == 2'd0, "R12 ctl_q", 32'(ctl_q), 0);

        ctl(3'b001);
        chk(ctl_q == 2'b01, "R8 ctl readback", 32'(ctl_q), 1);

        // R2 fill then hit, odd byte read also hits
        op(0, A, 0, 0, "R2 read miss");
        drain(); rd0 = n_mrd;
        op(0, A, 0, 0, "R2 read hit");
        op(0, A | 22'h1, 0, 0, "R2 odd byte read");
        drain();
        chk(n_mrd == rd0, "R2 no mem read on hit", 32'(n_mrd), 32'(rd0));

        // R3 word write allocate, then update
        op(1, B, 16'hBEEF, 0, "R3 word write miss");
        op(0, B, 0, 0, "R3 read after allocate");
        op(1, B, 16'h1357, 0, "R3 word write hit");
        op(0, B, 0, 0, "R3 read after update");

        // R4 byte write hit high lane, miss no allocate
        op(2, B | 22'h1, 16'h12FF, 0, "R4 high byte hit");
        drain();
        chk(last_mask == 2'b10, "R5 high byte mask", 32'(last_mask), 2);
        op(0, B, 0, 0, "R4 merged read");
        op(2, C, 16'h0066, 0, "R4 byte miss");
        drain();
        chk(last_mask == 2'b01, "R5 low byte mask", 32'(last_mask), 1);
        op(0, C, 0, 0, "R4 no allocate read");

        // R1 alias eviction
        op(0, B ^ 22'h002000, 0, 0, "R1 alias miss");
        op(0, B, 0, 0, "R1 evicted miss");

        // R6 snoop: matching tag clears, other tag keeps
        dma(B, 16'h7777);
        op(0, B, 0, 0, "R6 snooped line refetch");
        dma(A ^ 22'h002000, 16'h4444);
        op(0, A, 0, 0, "R6 other tag kept");

        // R7 bypass paths
        op(0, IO, 0, 0, "R7 io read 1");
        op(0, IO, 0, 0, "R7 io read 2");
        op(1, IO, 16'h0F0F, 0, "R7 io write");
        op(0, IO, 0, 0, "R7 io read 3");
        op(0, 22'h00C000, 0, 1, "R7 nocache 1");
        op(0, 22'h00C000, 0, 1, "R7 nocache 2");

        // R8 disabled cache
        ctl(3'b000);
        op(0, A, 0, 0, "R8 disabled read");
        op(1, 22'h010000, 16'h2222, 0, "R8 disabled write");
        ctl(3'b001);
        op(0, 22'h010000, 0, 0, "R8 no allocate while off");
        op(0, A, 0, 0, "R8 kept line hits");

        // R9 forced parity
        ctl(3'b011);
        op(1, F, 16'hCAFE, 0, "R9 forced write");
        ctl(3'b001);
        op(0, F, 0, 0, "R9 parity miss");
        op(0, F, 0, 0, "R9 refilled hit");

        // R10 flush sweep
        drain();
        ctl_we = 1'b1; ctl_wdata = 3'b101; rv.delete();
        @(negedge clk);
        ctl_we = 1'b0;
        lowc = 0;
        while (!cpu_ready && lowc < 10000) begin lowc++; @(negedge clk); end
        chk(lowc == DEPTH + 1, "R10 sweep length", 32'(lowc), DEPTH + 1);
        op(0, A, 0, 0, "R10 miss after flush");
        op(0, F, 0, 0, "R10 miss after flush F");
        op(0, A, 0, 0, "R10 refill hit");

        drain();
        chk(hist == rh, "R11 final history", 32'(hist), 32'(rh));
        chk(n_mwr == n_wr_issued, "R5 write-through count", 32'(n_mwr), 32'(n_wr_issued));
        chk(dev_rd(int'(B[21:1])) == 16'h7777, "R5 memory content", 32'(dev_rd(int'(B[21:1]))), 32'h7777);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R12 actual=%0h expected=%0h", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule